// File: doc/BRIEF.md
# I2C Master Clock Pacer

This block sets the pace of the serial clock in an I2C master. A 7-bit reload value, taken from a configuration register, sets the length of each SCL half period. A down counter measures that length. It moves only on a count tick that the surrounding logic supplies at twice the instruction rate. The block does not run freely. A start pulse, raised when software writes the transmit buffer, loads the counter and marks the block busy. Each time the count reaches zero on a tick, the block emits a one-cycle rollover strobe, toggles SCL and loads the counter again.

Two rollovers make one SCL period, so SCL runs at tick_rate / (2 × (reload + 1)). For example, with a 20 MHz tick a reload of 24 gives 400 kHz and a reload of 99 gives 100 kHz. After nine SCL periods (eight data bits plus the acknowledge) the block pulses done and returns to idle. The counter then halts at zero and SCL keeps its last level. A reload of zero is illegal: the start request is refused and an error strobe is raised. Each instance keeps its own captured reload value, so several instances fed by the same clock and tick run at independent rates.

Top module: `i2c_brg`

## Requirements
- R1: A synchronous active-high reset leaves scl at 1 (released) and busy, rollover, done and cfg_err at 0.
- R2: A start pulse while idle with a non-zero reload_val sets busy from the next cycle. The 7-bit reload_val present in that cycle becomes the active reload value.
- R3: While busy, the counter moves only in cycles with tick high. Each half period spans exactly reload+1 ticks, counted from the start or from the previous rollover, with the rollover tick included. rollover is high for one cycle per half period.
- R4: Each rollover inverts scl from the next cycle, so one SCL period equals 2 × (reload+1) ticks.
- R5: done is high together with the 18th rollover of a transfer (nine SCL periods). busy is low from the next cycle. After that, no further rollover occurs and scl holds its last level, which is 1 for a transfer that started from the released level.
- R6: A start pulse while idle with reload_val equal to 0 raises cfg_err in that same cycle and does not set busy.
- R7: A start pulse while busy has no effect. A change of reload_val during a transfer also has no effect: the half period length stays at the captured value and the transfer still ends after 18 rollovers.
- R8: While idle, tick pulses produce no rollover and leave scl unchanged.
- R9: Two instances that share clk and tick but have different reload values each produce half periods of their own reload+1 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, high one cycle per tick (twice the instruction rate) |
| start | input | 1 | Transfer request, raised when the transmit buffer is written |
| reload_val | input | 7 | Half period reload value, captured on an accepted start |
| scl | output | 1 | Serial clock level |
| busy | output | 1 | High while a transfer is being paced |
| rollover | output | 1 | One-cycle strobe when the count reaches zero on a tick |
| done | output | 1 | One-cycle strobe on the final rollover of a transfer |
| cfg_err | output | 1 | One-cycle strobe when a start is refused because reload_val is 0 |

## Verification
The assertions assume that tick, start and reload_val are synchronous to clk and that reset is applied before the first start. They also assume that start is a pulse the block may ignore while busy. A refused zero reload is expected to leave the block idle rather than to run a degenerate count. The stimulus changes inputs only between clock edges and sweeps every reload value from 1 to 40, plus 63 and 127, with a tick on every cycle. It also runs the 400 kHz and 100 kHz reload points with a tick on every second cycle and one case with a tick on every third cycle. Zero reloads, extra starts and reload changes during a transfer, and ticks while idle are applied only in dedicated phases, so each one can be checked on its own.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int unsigned RELOAD_W_DEF  = 7;
    localparam int unsigned XFER_BITS_DEF = 9;
endpackage

// File: rtl/brg_counter.sv
module brg_counter #(
    parameter int unsigned W = brg_pkg::RELOAD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         arm,
    input  logic [W-1:0] arm_val,
    input  logic         rearm,
    output logic         roll
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        roll = run && tick && (st_q.cnt == '0);
        st_d = st_q;
        if (arm) begin
            st_d.cnt = arm_val;
            st_d.rld = arm_val;
        end else if (rearm) begin
            st_d.cnt = st_q.rld;
        end else if (run && tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.rld);

    // R2
    arm_load_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (st_q.cnt == $past(arm_val)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !arm && !rearm) |=> $stable(st_q.cnt));
endmodule

// File: rtl/brg_seq.sv
module brg_seq #(
    parameter int unsigned HALVES = 2 * brg_pkg::XFER_BITS_DEF,
    localparam int unsigned HW    = $clog2(HALVES)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic val_zero,
    input  logic roll,
    output logic arm,
    output logic rearm,
    output logic busy,
    output logic scl,
    output logic done,
    output logic cfg_err
);
    typedef struct packed {
        logic          busy;
        logic          scl;
        logic [HW-1:0] half;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic accept, last;

    always_comb begin
        accept  = start && !st_q.busy;
        arm     = accept && !val_zero;
        cfg_err = accept && val_zero;
        last    = (st_q.half == HW'(HALVES - 1));
        done    = roll && last;
        rearm   = roll && !last;
        st_d    = st_q;
        if (arm) begin
            st_d.busy = 1'b1;
            st_d.half = '0;
        end else if (roll) begin
            st_d.scl = ~st_q.scl;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.half = '0;
            end else begin
                st_d.half = st_q.half + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.scl  <= 1'b1;
            st_q.half <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign scl  = st_q.scl;

    // R4
    scl_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        roll |=> (st_q.scl != $past(st_q.scl)));

    // R8
    idle_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && !roll) |=> $stable(st_q.scl));

    // R6
    zero_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !st_q.busy && val_zero) |=> !st_q.busy);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !st_q.busy);

    // R3
    roll_busy_chk: assert property (@(posedge clk) disable iff (rst)
        roll |-> st_q.busy);
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg #(
    parameter int unsigned RELOAD_W  = brg_pkg::RELOAD_W_DEF,
    parameter int unsigned XFER_BITS = brg_pkg::XFER_BITS_DEF,
    localparam int unsigned HALVES   = 2 * XFER_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic [RELOAD_W-1:0] reload_val,
    output logic                scl,
    output logic                busy,
    output logic                rollover,
    output logic                done,
    output logic                cfg_err
);
    logic arm, rearm, roll, val_zero;

    assign val_zero = (reload_val == '0);

    brg_counter #(.W(RELOAD_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(busy),
        .arm(arm), .arm_val(reload_val), .rearm(rearm), .roll(roll)
    );

    brg_seq #(.HALVES(HALVES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .val_zero(val_zero),
        .roll(roll), .arm(arm), .rearm(rearm), .busy(busy),
        .scl(scl), .done(done), .cfg_err(cfg_err)
    );

    assign rollover = roll;

    // R5
    rollover_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !rollover);
endmodule

// File: tb/i2c_brg_tb.sv
module i2c_brg_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [6:0] rv_a = 7'd0, rv_b = 7'd0;
    logic scl_v [2];
    logic busy_v [2];
    logic roll_v [2];
    logic done_v [2];
    logic err_v [2];

    int checks = 0, failures = 0, cycles = 0;
    int tick_div = 1, tcnt = 0;
    int exp_r [2];
    int tk [2];
    int rolls [2];
    int dones [2];
    logic prev_roll [2];
    logic prev_scl [2];

    always #10 clk = ~clk;

    i2c_brg u_dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start_a), .reload_val(rv_a),
        .scl(scl_v[0]), .busy(busy_v[0]), .rollover(roll_v[0]),
        .done(done_v[0]), .cfg_err(err_v[0])
    );

    i2c_brg u_dut_b (
        .clk(clk), .rst(rst), .tick(tick), .start(start_b), .reload_val(rv_b),
        .scl(scl_v[1]), .busy(busy_v[1]), .rollover(roll_v[1]),
        .done(done_v[1]), .cfg_err(err_v[1])
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cycles++;
        if (tcnt >= tick_div - 1) begin tcnt = 0; tick = 1'b1; end
        else begin tcnt++; tick = 1'b0; end
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                if (busy_v[i] && tick) tk[i]++;
                if (prev_roll[i]) chk(scl_v[i] != prev_scl[i], "R4 scl toggle", scl_v[i], !prev_scl[i]);
                if (roll_v[i]) begin
                    chk(busy_v[i], "R8 rollover only while busy", busy_v[i], 1);
                    chk(tk[i] == exp_r[i] + 1, (i == 0) ? "R3 half period ticks" : "R9 second instance ticks",
                        tk[i], exp_r[i] + 1);
                    rolls[i]++;
                    tk[i] = 0;
                end
                if (done_v[i]) begin
                    chk(roll_v[i] && rolls[i] == 18, "R5 done on 18th rollover", rolls[i], 18);
                    dones[i]++;
                end
                prev_roll[i] = roll_v[i];
                prev_scl[i] = scl_v[i];
            end
        end
    end

    task automatic clear_mon();
        for (int i = 0; i < 2; i++) begin
            tk[i] = 0; rolls[i] = 0; dones[i] = 0;
        end
    endtask

    task automatic run_xfer(input int ra, input int rb, input bit use_b);
        int busy_cycles;
        clear_mon();
        @(posedge clk); #2;
        rv_a = 7'(ra); start_a = 1'b1; exp_r[0] = ra;
        if (use_b) begin rv_b = 7'(rb); start_b = 1'b1; exp_r[1] = rb; end
        @(posedge clk); #2;
        start_a = 1'b0; start_b = 1'b0;
        @(negedge clk);
        chk(busy_v[0] == 1'b1, "R2 busy after start", busy_v[0], 1);
        busy_cycles = 0;
        while (busy_v[0] || busy_v[1]) begin
            if (busy_v[0]) busy_cycles++;
            @(negedge clk);
        end
        if (tick_div == 1)
            chk(busy_cycles == 18 * (ra + 1), "R4 transfer length", busy_cycles, 18 * (ra + 1));
        chk(rolls[0] == 18 && dones[0] == 1, "R5 rollover count", rolls[0], 18);
        chk(scl_v[0] == 1'b1, "R5 scl held", scl_v[0], 1);
        if (use_b) chk(rolls[1] == 18, "R9 second instance rollovers", rolls[1], 18);
    endtask

    initial begin
        exp_r[0] = 0; exp_r[1] = 0;
        for (int i = 0; i < 2; i++) begin prev_roll[i] = 1'b0; prev_scl[i] = 1'b1; end
        clear_mon();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(scl_v[0] == 1'b1 && busy_v[0] == 1'b0 && roll_v[0] == 1'b0 &&
            done_v[0] == 1'b0 && err_v[0] == 1'b0, "R1 reset state", busy_v[0], 0);
        @(posedge clk); #2;
        rst = 1'b0;

        // R2 R3 R4 R5: exhaustive low range plus large values, tick every cycle
        tick_div = 1;
        for (int r = 1; r <= 40; r++) run_xfer(r, 0, 1'b0);
        run_xfer(63, 0, 1'b0);
        run_xfer(127, 0, 1'b0);

        // R4 frequency points with a tick on every second cycle
        tick_div = 2;
        run_xfer(24, 0, 1'b0);
        run_xfer(99, 0, 1'b0);
        run_xfer(9, 0, 1'b0);
        tick_div = 3;
        run_xfer(5, 0, 1'b0);
        tick_div = 1;

        // R6 zero reload refused
        @(posedge clk); #2;
        rv_a = 7'd0; start_a = 1'b1;
        @(negedge clk);
        chk(err_v[0] == 1'b1, "R6 cfg_err on zero", err_v[0], 1);
        @(posedge clk); #2;
        start_a = 1'b0;
        @(negedge clk);
        chk(busy_v[0] == 1'b0, "R6 no start on zero", busy_v[0], 0);
        chk(err_v[0] == 1'b0, "R6 cfg_err one cycle", err_v[0], 0);

        // R7 restart and reload change while busy ignored
        clear_mon();
        @(posedge clk); #2;
        rv_a = 7'd4; start_a = 1'b1; exp_r[0] = 4;
        @(posedge clk); #2;
        start_a = 1'b0;
        repeat (20) @(posedge clk);
        #2; rv_a = 7'd9; start_a = 1'b1;
        @(posedge clk); #2;
        start_a = 1'b0;
        while (busy_v[0]) @(negedge clk);
        chk(rolls[0] == 18 && dones[0] == 1, "R7 restart ignored", rolls[0], 18);

        // R8 ticks while idle
        clear_mon();
        begin
            logic s0;
            @(negedge clk);
            s0 = scl_v[0];
            repeat (30) @(negedge clk);
            chk(rolls[0] == 0 && rolls[1] == 0, "R8 no idle rollover", rolls[0] + rolls[1], 0);
            chk(scl_v[0] == s0, "R8 idle scl stable", scl_v[0], s0);
        end

        // R9 two instances at different rates
        run_xfer(3, 7, 1'b1);
        tick_div = 2;
        run_xfer(12, 2, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule